// File: doc/BRIEF.md
# Boot Coefficient Loader

This block fills the coefficient RAM of a filter datapath. Coefficients arrive by one of two routes: a host writes single words through a simple write port, or the block reads a whole set from an external parallel read-only memory. In the memory case the block drives the memory address itself. A static source-select input chooses the route. In memory mode a full load runs by itself once power-on reset is released. A change-coefficient request starts another full load at any later time.

Up to sixteen filter devices can share one memory. Each device is strapped with a device index, and the block places that index in the upper address bits. Each device therefore reads its own 2^IDX_W-word region. The memory returns data a fixed, parameterized number of cycles after the address is presented, and the loader waits exactly that long before each RAM write. While a load runs, `busy` is high so the filter can hold its valid output low. `done` pulses once when the last word has been written. A request that arrives during a load is remembered, and a new load follows straight after the current one. Host writes are blocked for the whole of a load.

Top module: `coef_boot_loader`

## Requirements
- R1: With `src_mem` high, releasing `rst_n` starts a load with no further request: `busy` is high from the first clock edge after release, and the load begins at coefficient index 0.
- R2: The memory address is `{dev_idx, coefficient index}`. The device index sits in the upper DEV_W bits and the coefficient index in the lower IDX_W bits.
- R3: The loader writes coefficient indices 0 to NUM_COEF-1 in ascending order, one word every WAIT_CYC+1 cycles. Each word is written in the cycle WAIT_CYC cycles after its address first appears. The write carries `cram_addr` equal to the index and `cram_data` equal to `rom_data` in that cycle.
- R4: `busy` stays high from the first cycle of a load until the cycle after its last write, where it falls unless a new load follows.
- R5: `done` is high for exactly one cycle, the cycle after the last write of a load, and at no other time.
- R6: A `chg_req` pulse while idle with `src_mem` high starts a full load at the next clock edge.
- R7: A `chg_req` during a load, including in the cycle of its last write, is latched. The next load starts in the cycle after that last write, with no idle cycle between, so `busy` stays high. Several requests during one load cause only one further load.
- R8: While no load runs, a host write (`host_we` high) appears on the RAM write port in the same cycle with the host's address and data.
- R9: Host writes during a load are ignored: the RAM port carries only the loader's own writes.
- R10: With `src_mem` low, neither reset release nor `chg_req` starts a load, and a request made in that mode is not kept for later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| src_mem | input | 1 | 1: coefficients come from external memory; 0: host only |
| dev_idx | input | DEV_W | Device index selecting this device's memory region |
| chg_req | input | 1 | Change-coefficient request (one-cycle pulse) |
| host_we | input | 1 | Host write strobe |
| host_addr | input | IDX_W | Host write coefficient index |
| host_data | input | DATA_W | Host write coefficient (two's complement) |
| rom_addr | output | DEV_W+IDX_W | External memory address |
| rom_rd_en | output | 1 | External memory read enable, high during a load |
| rom_data | input | DATA_W | External memory read data |
| cram_we | output | 1 | Coefficient RAM write enable |
| cram_addr | output | IDX_W | Coefficient RAM write address |
| cram_data | output | DATA_W | Coefficient RAM write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse at the end of each load |

## Verification
The bench builds the block with NUM_COEF=12 and WAIT_CYC=3, with the default 4-bit device index and 7-bit region. A load then takes only 48 cycles, so the bench can run many back-to-back and restarted loads in a short run. Because the count ends at 11 rather than at a power-of-two wrap, an error in the terminal count shows up. The memory model delays its data by three cycles, so any write taken one cycle early picks up the previous word's data, and the scoreboard flags it.

// File: rtl/cbl_pkg.sv
package cbl_pkg;
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_e;
endpackage

// File: rtl/cbl_wait_ctr.sv
module cbl_wait_ctr #(
    parameter int WAIT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic expired
);
    localparam int CNT_W = (WAIT_CYC > 0) ? $clog2(WAIT_CYC + 1) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WAIT_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expired = (cnt_q == LIMIT);

    always_comb begin
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (!expired) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cbl_seq.sv
module cbl_seq
    import cbl_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int NUM_COEF = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_mem,
    input  logic             chg_req,
    input  logic             expired,
    output logic             ctr_clear,
    output logic             busy,
    output logic             wr_stb,
    output logic [IDX_W-1:0] wr_idx,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COEF - 1);

    typedef struct packed {
        ld_state_e        st;
        logic [IDX_W-1:0] idx;
        logic             pend;
        logic             done;
    } seq_t;

    seq_t s_d, s_q;
    logic run_q;
    logic wr_now;

    assign run_q  = (s_q.st == LD_RUN);
    assign wr_now = run_q && expired;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.st)
            LD_IDLE: begin
                if (src_mem && (s_q.pend || chg_req)) begin
                    s_d.st  = LD_RUN;
                    s_d.idx = '0;
                end
                s_d.pend = 1'b0;
            end
            LD_RUN: begin
                s_d.pend = s_q.pend || chg_req;
                if (wr_now) begin
                    if (s_q.idx == LAST_IDX) begin
                        s_d.done = 1'b1;
                        s_d.idx  = '0;
                        if (s_q.pend || chg_req) begin
                            s_d.pend = 1'b0;
                        end else begin
                            s_d.st = LD_IDLE;
                        end
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st   <= LD_IDLE;
            s_q.idx  <= '0;
            s_q.pend <= 1'b1;
            s_q.done <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ctr_clear = !run_q || wr_now;
    assign busy      = run_q;
    assign wr_stb    = wr_now;
    assign wr_idx    = s_q.idx;
    assign done      = s_q.done;
endmodule

// File: rtl/cbl_wr_mux.sv
module cbl_wr_mux #(
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input  logic              load_active,
    input  logic              load_we,
    input  logic [IDX_W-1:0]  load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_data,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    always_comb begin
        if (load_active) begin
            wr_en   = load_we;
            wr_addr = load_addr;
            wr_data = load_data;
        end else begin
            wr_en   = host_we;
            wr_addr = host_addr;
            wr_data = host_data;
        end
    end
endmodule

// File: rtl/coef_boot_loader.sv
module coef_boot_loader #(
    parameter int DEV_W    = 4,
    parameter int IDX_W    = 7,
    parameter int DATA_W   = 16,
    parameter int NUM_COEF = 128,
    parameter int WAIT_CYC = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   src_mem,
    input  logic [DEV_W-1:0]       dev_idx,
    input  logic                   chg_req,
    input  logic                   host_we,
    input  logic [IDX_W-1:0]       host_addr,
    input  logic [DATA_W-1:0]      host_data,
    output logic [DEV_W+IDX_W-1:0] rom_addr,
    output logic                   rom_rd_en,
    input  logic [DATA_W-1:0]      rom_data,
    output logic                   cram_we,
    output logic [IDX_W-1:0]       cram_addr,
    output logic [DATA_W-1:0]      cram_data,
    output logic                   busy,
    output logic                   done
);
    logic             expired;
    logic             ctr_clear;
    logic             seq_busy;
    logic             wr_stb;
    logic [IDX_W-1:0] wr_idx;

    cbl_wait_ctr #(.WAIT_CYC(WAIT_CYC)) u_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ctr_clear),
        .expired (expired)
    );

    cbl_seq #(.IDX_W(IDX_W), .NUM_COEF(NUM_COEF)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_mem   (src_mem),
        .chg_req   (chg_req),
        .expired   (expired),
        .ctr_clear (ctr_clear),
        .busy      (seq_busy),
        .wr_stb    (wr_stb),
        .wr_idx    (wr_idx),
        .done      (done)
    );

    cbl_wr_mux #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mux (
        .load_active (seq_busy),
        .load_we     (wr_stb),
        .load_addr   (wr_idx),
        .load_data   (rom_data),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_data   (host_data),
        .wr_en       (cram_we),
        .wr_addr     (cram_addr),
        .wr_data     (cram_data)
    );

    assign rom_addr  = {dev_idx, wr_idx};
    assign rom_rd_en = seq_busy;
    assign busy      = seq_busy;
endmodule

// File: rtl/cbl_checker.sv
module cbl_checker #(
    parameter int DEV_W  = 4,
    parameter int IDX_W  = 7,
    parameter int DATA_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   src_mem,
    input logic [DEV_W-1:0]       dev_idx,
    input logic [DEV_W+IDX_W-1:0] rom_addr,
    input logic [DATA_W-1:0]      rom_data,
    input logic                   cram_we,
    input logic [IDX_W-1:0]       cram_addr,
    input logic [DATA_W-1:0]      cram_data,
    input logic                   busy,
    input logic                   done
);
    AST_ROM_DEV_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rom_addr[DEV_W+IDX_W-1:IDX_W] == dev_idx); // R2
    AST_LOAD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cram_we) |-> cram_data == rom_data); // R3
    AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cram_we) |-> cram_addr == rom_addr[IDX_W-1:0]); // R3
    AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R4
    AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(cram_we)); // R5
    AST_HOST_MODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !src_mem) |=> !busy); // R10
endmodule

bind coef_boot_loader cbl_checker #(
    .DEV_W(DEV_W), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_cbl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_mem   (src_mem),
    .dev_idx   (dev_idx),
    .rom_addr  (rom_addr),
    .rom_data  (rom_data),
    .cram_we   (cram_we),
    .cram_addr (cram_addr),
    .cram_data (cram_data),
    .busy      (busy),
    .done      (done)
);

// File: tb/tb_coef_boot_loader.sv
`timescale 1ns/1ps
module tb_coef_boot_loader;
    localparam int DEV_W    = 4;
    localparam int IDX_W    = 7;
    localparam int DATA_W   = 16;
    localparam int NUM_COEF = 12;
    localparam int WAIT_CYC = 3;
    localparam int ROM_AW   = DEV_W + IDX_W;
    localparam int LOAD_LEN = NUM_COEF * (WAIT_CYC + 1);

    logic              clk = 1'b0;
    logic              rst_n, src_mem, chg_req, host_we;
    logic [DEV_W-1:0]  dev_idx;
    logic [IDX_W-1:0]  host_addr;
    logic [DATA_W-1:0] host_data;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_rd_en;
    logic [DATA_W-1:0] rom_data;
    logic              cram_we;
    logic [IDX_W-1:0]  cram_addr;
    logic [DATA_W-1:0] cram_data;
    logic              busy, done;

    always #2.5 clk = ~clk;

    coef_boot_loader #(
        .DEV_W(DEV_W), .IDX_W(IDX_W), .DATA_W(DATA_W),
        .NUM_COEF(NUM_COEF), .WAIT_CYC(WAIT_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .src_mem(src_mem), .dev_idx(dev_idx),
        .chg_req(chg_req), .host_we(host_we), .host_addr(host_addr),
        .host_data(host_data), .rom_addr(rom_addr), .rom_rd_en(rom_rd_en),
        .rom_data(rom_data), .cram_we(cram_we), .cram_addr(cram_addr),
        .cram_data(cram_data), .busy(busy), .done(done)
    );

    function automatic logic [DATA_W-1:0] rom_val(input logic [ROM_AW-1:0] a);
        logic [31:0] t;
        t = 32'(a) * 32'd613 + 32'd1234;
        return t[DATA_W-1:0] ^ 16'h8000;
    endfunction

    // memory model: data follows the address by WAIT_CYC cycles
    logic [ROM_AW-1:0] apipe [WAIT_CYC];
    always_ff @(posedge clk) begin
        apipe[0] <= rom_addr;
        for (int i = 1; i < WAIT_CYC; i++) apipe[i] <= apipe[i-1];
    end
    assign rom_data = rom_val(apipe[WAIT_CYC-1]);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int tests = 0;
    int fails = 0;

    typedef struct {
        int                cy;
        logic [IDX_W-1:0]  a;
        logic [DATA_W-1:0] d;
        string             req;
    } wr_t;
    wr_t wq[$];
    int  dq[$];
    wr_t e;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic expect_load(input int k0, input logic [DEV_W-1:0] dev, input string req);
        for (int i = 0; i < NUM_COEF; i++) begin
            wq.push_back('{k0 + i * (WAIT_CYC + 1) + WAIT_CYC, IDX_W'(i),
                           rom_val({dev, IDX_W'(i)}), req});
        end
        dq.push_back(k0 + LOAD_LEN);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic at_cycle(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            while (wq.size() > 0 && wq[0].cy < cyc) begin
                e = wq.pop_front();
                check(1'b0, e.req, "missing write at index", cyc, e.cy);
            end
            if (cram_we) begin
                if (wq.size() == 0 || wq[0].cy != cyc) begin
                    check(1'b0, "R9", "unexpected RAM write addr", cram_addr, 0);
                end else begin
                    e = wq.pop_front();
                    check(cram_addr == e.a, e.req, "write address", cram_addr, e.a);
                    check(cram_data == e.d, e.req, "write data", cram_data, e.d);
                end
            end
            if (dq.size() > 0 && dq[0] == cyc) begin
                void'(dq.pop_front());
                check(done == 1'b1, "R5", "done pulse", done, 1);
            end else if (done) begin
                check(1'b0, "R5", "done outside end of load", done, 0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL R4 watchdog: actual cycle %0d expected below 20000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int k0, k1, k2, k3, lastw;
        rst_n = 1'b0; src_mem = 1'b1; dev_idx = 4'd5; chg_req = 1'b0;
        host_we = 1'b0; host_addr = '0; host_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(done == 1'b0, "R5", "done in reset", done, 0);
        check(cram_we == 1'b0, "R1", "write enable in reset", cram_we, 0);

        // R1 automatic boot load
        step();
        rst_n = 1'b1;
        k0 = cyc + 1;
        expect_load(k0, 4'd5, "R1");
        at_cycle(k0);
        check(busy == 1'b1, "R1", "busy after reset release", busy, 1);
        check(rom_addr == {4'd5, 7'd0}, "R2", "first memory address", rom_addr, {4'd5, 7'd0});
        check(rom_rd_en == 1'b1, "R1", "memory read enable", rom_rd_en, 1);
        at_cycle(k0 + WAIT_CYC + 1);
        check(rom_addr == {4'd5, 7'd1}, "R2", "second memory address", rom_addr, {4'd5, 7'd1});
        at_cycle(k0 + LOAD_LEN - 1);
        check(busy == 1'b1, "R4", "busy before last write ends", busy, 1);
        at_cycle(k0 + LOAD_LEN);
        check(busy == 1'b0, "R4", "busy after load", busy, 0);

        // R8 host writes while idle
        for (int j = 0; j < 3; j++) begin
            step();
            host_we = 1'b1;
            host_addr = IDX_W'(j * 5 + 2);
            host_data = DATA_W'(16'h1F00 + j * 16'h0111);
            wq.push_back('{cyc, host_addr, host_data, "R8"});
        end
        step();
        host_we = 1'b0;
        check(busy == 1'b0, "R8", "no load from host writes", busy, 0);

        // R6 request while idle, new device region
        dev_idx = 4'd11;
        step();
        chg_req = 1'b1;
        k1 = cyc + 1;
        expect_load(k1, 4'd11, "R6");
        step();
        chg_req = 1'b0;
        check(busy == 1'b1, "R6", "busy after request", busy, 1);
        check(rom_addr[ROM_AW-1:IDX_W] == 4'd11, "R2", "device field", rom_addr[ROM_AW-1:IDX_W], 11);

        // R9 host writes during load, R7 two requests collapse to one reload
        at_cycle(k1 + 5);
        for (int j = 0; j < 6; j++) begin
            step();
            host_we = 1'b1;
            host_addr = IDX_W'(40 + j);
            host_data = 16'hDEAD;
            chg_req = (j == 1 || j == 4);
        end
        step();
        host_we = 1'b0;
        chg_req = 1'b0;
        k2 = k1 + LOAD_LEN;
        expect_load(k2, 4'd11, "R7");
        at_cycle(k2);
        check(busy == 1'b1, "R7", "busy kept across reload", busy, 1);
        check(rom_addr == {4'd11, 7'd0}, "R7", "reload restarts at index 0", rom_addr, {4'd11, 7'd0});

        // R7 request in the cycle of the last write
        lastw = k2 + (NUM_COEF - 1) * (WAIT_CYC + 1) + WAIT_CYC;
        at_cycle(lastw - 1);
        step();
        chg_req = 1'b1;
        step();
        chg_req = 1'b0;
        k3 = lastw + 1;
        expect_load(k3, 4'd11, "R7");
        at_cycle(k3 + LOAD_LEN);
        check(busy == 1'b0, "R4", "idle after final reload", busy, 0);
        at_cycle(k3 + 2 * LOAD_LEN);
        check(busy == 1'b0, "R7", "no extra reload", busy, 0);

        // R10 host-only mode
        rst_n = 1'b0;
        src_mem = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        check(busy == 1'b0, "R10", "no boot load in host mode", busy, 0);
        chg_req = 1'b1;
        step();
        chg_req = 1'b0;
        repeat (LOAD_LEN) step();
        check(busy == 1'b0, "R10", "request ignored in host mode", busy, 0);
        host_we = 1'b1;
        host_addr = 7'd99;
        host_data = 16'h7ABC;
        wq.push_back('{cyc, host_addr, host_data, "R10"});
        step();
        host_we = 1'b0;
        src_mem = 1'b1;
        repeat (6) step();
        check(busy == 1'b0, "R10", "request from host mode not kept", busy, 0);

        // R6 memory mode again: request works
        chg_req = 1'b1;
        k0 = cyc + 1;
        expect_load(k0, 4'd11, "R6");
        step();
        chg_req = 1'b0;
        at_cycle(k0 + LOAD_LEN + 4);
        check(busy == 1'b0, "R4", "idle after last load", busy, 0);
        check(wq.size() == 0, "R3", "writes outstanding", wq.size(), 0);
        check(dq.size() == 0, "R5", "done pulses outstanding", dq.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule